// File: doc/BRIEF.md
# Synchronous No-Turnaround SRAM Core

This block is a cycle-accurate synchronous static RAM built for a read/write bus that never idles. The rising clock edge captures the address, the command and the byte enables. Write data follows its address by a fixed number of cycles (late write), in the same bus slot where a read issued at that point would return data. Any mix of reads and writes can therefore be issued on consecutive cycles with no gap cycle when the bus changes direction.

A static mode pin picks the read path. In pipelined operation an output register adds one cycle. In flow-through operation the array register drives the output directly. A second static pin picks linear or interleaved order for four-beat bursts. Three chip selects of mixed polarity gate every new command. Two asynchronous pins act on the output: an output enable and a sleep input, which also blocks new commands. A read that follows a pending write to the same word still returns the new data.

Top module: `sram_nbt_core`

## Requirements
- R1: A write takes its data from `din` at the rising edge one cycle after the address edge when `pipe_mode`=0, and two cycles after it when `pipe_mode`=1.
- R2: With `pipe_mode`=0, a read accepted at edge n drives its word on `dout` with `dout_drv`=1 after edge n+1, so the host samples it at edge n+2.
- R3: With `pipe_mode`=1, a read accepted at edge n drives its word after edge n+2, so the host samples it at edge n+3.
- R4: Reads and writes can be accepted on every cycle in any order, with no idle cycle between them.
- R5: `ld`=1 starts a command at `addr`, and `wr`=1 makes it a write. Each later cycle with `ld`=0 issues the next beat of the same type. The 2 low address bits of that beat are (start + beat) mod 4 when `lin_order`=1, and the upper bits stay fixed.
- R6: When `lin_order`=0, the 2 low address bits of a beat are start XOR beat, where beat counts 0..3 and then wraps.
- R7: `byte_en[i]`=1 writes `din[9i+8:9i]`. Bytes with the bit at 0 keep their old value, and a mask of 0 leaves the word unchanged. The mask is sampled on every accepted beat.
- R8: A command is accepted only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. `ld`=1 with any other combination is a deselect: it changes no word, drives no data and ends any burst, so a later `ld`=0 cycle issues nothing.
- R9: `oe_n`=1 forces `dout_drv` to 0 at once. It does not change the array or the commands in flight.
- R10: While `sleep`=1, no command or burst beat is accepted, any burst ends and `dout_drv` is 0. Writes accepted before sleep still take their data.
- R11: A read accepted right after a write to the same word returns the written bytes, in either mode.
- R12: When `dout_drv`=0, `dout` is all zeros.
- R13: After reset, no command is pending and `dout_drv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pipe_mode | input | 1 | Static: 1 pipelined, 0 flow-through |
| lin_order | input | 1 | Static: 1 linear burst order, 0 interleaved |
| en_a_n | input | 1 | Chip select, active low |
| en_b | input | 1 | Chip select, active high |
| en_c_n | input | 1 | Chip select, active low |
| sleep | input | 1 | Asynchronous power-down; blocks commands, turns the output off |
| oe_n | input | 1 | Asynchronous output enable, active low |
| ld | input | 1 | 1 loads a new command, 0 advances the current burst |
| wr | input | 1 | Command type when `ld`=1: 1 write, 0 read |
| addr | input | ADDR_W | Word address, sampled when `ld`=1 |
| byte_en | input | NBYTES | Per-byte write enable, active high |
| din | input | BYTE_W*NBYTES | Late write data |
| dout | output | BYTE_W*NBYTES | Read data, zero when not driven |
| dout_drv | output | 1 | Output drive enable (0 stands for high impedance) |

## Verification
The bench uses the default parameters: 64 words of four 9-bit bytes. With that size every address can be written and read back, every start offset within a 4-word block can open a burst, and all 16 byte masks and all 8 chip-select combinations can be tried. The same sweeps run under all four combinations of pipelined or flow-through mode and linear or interleaved order. This covers write-then-read forwarding at both latencies, alternating commands, and sleep or output-enable changes while reads are in flight.

// File: rtl/sram_nbt_pkg.sv
package sram_nbt_pkg;

  // A burst is four beats; the beat index selects the 2 low address bits.
  localparam int BEAT_W = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef struct packed {
    logic vld;
    logic wr;
  } op_t;

  // Low address bits of a beat, given the start offset and the beat index.
  function automatic beat_t beat_low(input beat_t start, input beat_t idx, input logic linear);
    beat_t res;
    if (linear) res = beat_t'(start + idx);
    else        res = start ^ idx;
    return res;
  endfunction

endpackage

// File: rtl/sram_nbt_issue.sv
module sram_nbt_issue
  import sram_nbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lin_order,
  input  logic              sleep,
  input  logic              ld,
  input  logic              wr,
  input  logic              en_a_n,
  input  logic              en_b,
  input  logic              en_c_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBYTES-1:0] byte_en,
  output op_t               a_op,
  output logic [ADDR_W-1:0] a_addr,
  output logic [NBYTES-1:0] a_be
);

  logic              sel_ok;
  logic              burst_q, burst_d;
  logic              bwr_q, bwr_d;
  logic [ADDR_W-1:0] base_q, base_d;
  beat_t             cnt_q, cnt_d;
  op_t               op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [NBYTES-1:0] be_q, be_d;

  assign sel_ok = !en_a_n && en_b && !en_c_n;

  // Next-state: load, advance, deselect or sleep.
  always_comb begin
    burst_d = burst_q;
    bwr_d   = bwr_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    op_d    = '0;
    addr_d  = addr_q;
    be_d    = be_q;
    if (sleep) begin
      burst_d = 1'b0;
    end else if (ld) begin
      if (sel_ok) begin
        burst_d = 1'b1;
        bwr_d   = wr;
        base_d  = addr;
        cnt_d   = '0;
        op_d.vld = 1'b1;
        op_d.wr  = wr;
        addr_d  = addr;
        be_d    = byte_en;
      end else begin
        burst_d = 1'b0;
      end
    end else if (burst_q) begin
      cnt_d    = cnt_q + beat_t'(1);
      op_d.vld = 1'b1;
      op_d.wr  = bwr_q;
      addr_d   = {base_q[ADDR_W-1:BEAT_W], beat_low(base_q[BEAT_W-1:0], cnt_d, lin_order)};
      be_d     = byte_en;
    end
  end

  // Control state, reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0;
      op_q    <= '0;
    end else begin
      burst_q <= burst_d;
      op_q    <= op_d;
    end
  end

  // Datapath state, no reset; only read while a qualifying flag is set.
  always_ff @(posedge clk) begin
    bwr_q  <= bwr_d;
    base_q <= base_d;
    cnt_q  <= cnt_d;
    addr_q <= addr_d;
    be_q   <= be_d;
  end

  assign a_op   = op_q;
  assign a_addr = addr_q;
  assign a_be   = be_q;

endmodule

// File: rtl/sram_nbt_late.sv
module sram_nbt_late #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [NBYTES-1:0] a_be,
  output logic              cm_en,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [NBYTES-1:0] cm_be
);

  logic              b_wr_q;
  logic [ADDR_W-1:0] b_addr_q, b_addr_d;
  logic [NBYTES-1:0] b_be_q, b_be_d;

  // Clock enable: second-stage write fields load only behind a write.
  always_comb begin
    b_addr_d = a_wr ? a_addr : b_addr_q;
    b_be_d   = a_wr ? a_be   : b_be_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_wr_q <= 1'b0;
    else        b_wr_q <= a_wr;
  end

  always_ff @(posedge clk) begin
    b_addr_q <= b_addr_d;
    b_be_q   <= b_be_d;
  end

  // Commit one stage later in pipelined mode (data two cycles late).
  always_comb begin
    if (pipe_mode) begin
      cm_en   = b_wr_q;
      cm_addr = b_addr_q;
      cm_be   = b_be_q;
    end else begin
      cm_en   = a_wr;
      cm_addr = a_addr;
      cm_be   = a_be;
    end
  end

endmodule

// File: rtl/sram_nbt_array.sv
module sram_nbt_array #(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4,
  localparam int DATA_W = BYTE_W * NBYTES,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NBYTES-1:0] wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] fwd;
  logic [DATA_W-1:0] rd_q, rd_d;

  // Array word merged with the bytes committing on this same edge.
  always_comb begin
    fwd = mem[rd_addr];
    for (int i = 0; i < NBYTES; i++) begin
      if (wr_en && wr_be[i] && (wr_addr == rd_addr))
        fwd[i*BYTE_W +: BYTE_W] = wr_data[i*BYTE_W +: BYTE_W];
    end
    rd_d = rd_en ? fwd : rd_q;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NBYTES; i++) begin
      if (wr_en && wr_be[i])
        mem[wr_addr][i*BYTE_W +: BYTE_W] <= wr_data[i*BYTE_W +: BYTE_W];
    end
    rd_q <= rd_d;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/sram_nbt_out.sv
module sram_nbt_out #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic              a_rd,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_drv
);

  logic              b_rd_q, c_rd_q;
  logic [DATA_W-1:0] out_q, out_d;
  logic              slot_rd;
  logic [DATA_W-1:0] slot_data;

  // Output register loads only when the array register holds a read.
  always_comb out_d = b_rd_q ? rd_data : out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_rd_q <= 1'b0;
      c_rd_q <= 1'b0;
    end else begin
      b_rd_q <= a_rd;
      c_rd_q <= b_rd_q;
    end
  end

  always_ff @(posedge clk) out_q <= out_d;

  always_comb begin
    slot_rd   = pipe_mode ? c_rd_q : b_rd_q;
    slot_data = pipe_mode ? out_q  : rd_data;
  end

  // Asynchronous overrides act after the last register.
  assign dout_drv = slot_rd && !oe_n && !sleep;
  assign dout     = dout_drv ? slot_data : '0;

endmodule

// File: rtl/sram_nbt_core.sv
module sram_nbt_core
  import sram_nbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4,
  localparam int DATA_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              lin_order,
  input  logic              en_a_n,
  input  logic              en_b,
  input  logic              en_c_n,
  input  logic              sleep,
  input  logic              oe_n,
  input  logic              ld,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBYTES-1:0] byte_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_drv
);

  logic [1:0]        rs_q;
  logic              rst_core_n;
  op_t               a_op;
  logic [ADDR_W-1:0] a_addr;
  logic [NBYTES-1:0] a_be;
  logic              a_rd, a_wr;
  logic              cm_en;
  logic [ADDR_W-1:0] cm_addr;
  logic [NBYTES-1:0] cm_be;
  logic [DATA_W-1:0] rd_data;

  // Reset asserts asynchronously, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign a_rd = a_op.vld && !a_op.wr;
  assign a_wr = a_op.vld &&  a_op.wr;

  sram_nbt_issue #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) i_issue (
    .clk(clk), .rst_n(rst_core_n), .lin_order(lin_order), .sleep(sleep),
    .ld(ld), .wr(wr), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
    .addr(addr), .byte_en(byte_en),
    .a_op(a_op), .a_addr(a_addr), .a_be(a_be)
  );

  sram_nbt_late #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) i_late (
    .clk(clk), .rst_n(rst_core_n), .pipe_mode(pipe_mode),
    .a_wr(a_wr), .a_addr(a_addr), .a_be(a_be),
    .cm_en(cm_en), .cm_addr(cm_addr), .cm_be(cm_be)
  );

  sram_nbt_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) i_array (
    .clk(clk), .rd_en(a_rd), .rd_addr(a_addr),
    .wr_en(cm_en), .wr_addr(cm_addr), .wr_be(cm_be), .wr_data(din),
    .rd_data(rd_data)
  );

  sram_nbt_out #(.DATA_W(DATA_W)) i_out (
    .clk(clk), .rst_n(rst_core_n), .pipe_mode(pipe_mode), .oe_n(oe_n),
    .sleep(sleep), .a_rd(a_rd), .rd_data(rd_data),
    .dout(dout), .dout_drv(dout_drv)
  );

endmodule

// File: rtl/sram_nbt_chk.sv
module sram_nbt_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              en_a_n,
  input logic              en_b,
  input logic              en_c_n,
  input logic              sleep,
  input logic              oe_n,
  input logic              ld,
  input logic              wr,
  input logic [DATA_W-1:0] dout,
  input logic              dout_drv
);

  logic sel_ok;
  assign sel_ok = !en_a_n && en_b && !en_c_n;

  // R2: flow-through read is driven two edges after its address edge
  a_r2_flow_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && ld && !wr && sel_ok && !sleep) |=> ##1 (oe_n || sleep || dout_drv));

  // R3: pipelined read is driven three edges after its address edge
  a_r3_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && ld && !wr && sel_ok && !sleep) |=> ##2 (oe_n || sleep || dout_drv));

  // R8: a deselect cycle never produces a driven read slot
  a_r8_flow_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && ld && !sel_ok) |=> ##1 !dout_drv);

  a_r8_pipe_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && ld && !sel_ok) |=> ##2 !dout_drv);

  // R9: output enable high keeps the bus undriven
  a_r9_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_drv);

  // R10: a cycle issued in sleep yields no read slot
  a_r10_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && sleep) |=> ##1 !dout_drv);

  a_r10_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_drv);

  // R12: undriven data bus reads as zero
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_drv |-> (dout == '0));

endmodule

bind sram_nbt_core sram_nbt_chk #(.DATA_W(BYTE_W * NBYTES)) i_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
  .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
  .sleep(sleep), .oe_n(oe_n), .ld(ld), .wr(wr),
  .dout(dout), .dout_drv(dout_drv)
);

// File: tb/test_sram_nbt_core.sv
module test_sram_nbt_core;
  localparam int ADDR_W = 6;
  localparam int BYTE_W = 9;
  localparam int NBYTES = 4;
  localparam int DATA_W = BYTE_W * NBYTES;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [NBYTES-1:0] ALL = '1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, pipe_mode, lin_order, en_a_n, en_b, en_c_n, sleep, oe_n, ld, wr;
  logic [ADDR_W-1:0] addr;
  logic [NBYTES-1:0] byte_en;
  logic [DATA_W-1:0] din, dout;
  logic              dout_drv;

  sram_nbt_core #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) i_sram_nbt_core (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .lin_order(lin_order),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .sleep(sleep), .oe_n(oe_n),
    .ld(ld), .wr(wr), .addr(addr), .byte_en(byte_en), .din(din),
    .dout(dout), .dout_drv(dout_drv)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [DATA_W-1:0] ref_mem [DEPTH];
  logic              s_wv [8];
  logic [DATA_W-1:0] s_wd [8];
  logic              s_rv [8];
  logic [DATA_W-1:0] s_rd [8];
  string             s_tag [8];

  logic m_act, m_wr;
  int   m_base, m_cnt;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int c, input int a);
    logic [63:0] v;
    v = (64'(c) * 64'h9E3779B97F4A7C15) ^ (64'(a) << 21) ^ 64'h5A5;
    return v[DATA_W-1:0];
  endfunction

  // One bus cycle: drive at the falling edge, sample at the next falling edge.
  task automatic step(input logic i_ld, input logic i_wr, input int i_addr,
                      input logic [NBYTES-1:0] i_be, input string tag);
    int lat, now_s, out_s, aa, lo;
    logic acc, awr, sel, exp_drv;
    logic [DATA_W-1:0] data, exp_dat;
    lat   = pipe_mode ? 2 : 1;
    now_s = cyc % 8;
    out_s = (cyc + lat) % 8;
    ld = i_ld; wr = i_wr; addr = ADDR_W'(i_addr); byte_en = i_be;
    din = s_wv[now_s] ? s_wd[now_s] : ~pat(cyc + 777, 3);
    s_wv[now_s] = 1'b0;
    sel = !en_a_n && en_b && !en_c_n;
    acc = 1'b0; awr = 1'b0; aa = 0;
    if (sleep) m_act = 1'b0;
    else if (i_ld) begin
      if (sel) begin
        acc = 1'b1; awr = i_wr; aa = i_addr;
        m_act = 1'b1; m_wr = i_wr; m_base = i_addr; m_cnt = 0;
      end else m_act = 1'b0;
    end else if (m_act) begin
      m_cnt = (m_cnt + 1) % 4;
      lo = lin_order ? ((m_base % 4) + m_cnt) % 4 : ((m_base % 4) ^ m_cnt);
      aa = (m_base / 4) * 4 + lo;
      acc = 1'b1; awr = m_wr;
    end
    if (acc && awr) begin
      data = pat(cyc, aa);
      for (int b = 0; b < NBYTES; b++)
        if (i_be[b]) ref_mem[aa][b*BYTE_W +: BYTE_W] = data[b*BYTE_W +: BYTE_W];
      s_wv[out_s] = 1'b1; s_wd[out_s] = data;
    end
    if (acc && !awr) begin
      s_rv[out_s] = 1'b1; s_rd[out_s] = ref_mem[aa]; s_tag[out_s] = tag;
    end
    @(posedge clk);
    @(negedge clk);
    exp_drv = s_rv[now_s] && !oe_n && !sleep;
    exp_dat = exp_drv ? s_rd[now_s] : '0;
    check({s_rv[now_s] ? s_tag[now_s] : tag, " drive"}, 64'(dout_drv), 64'(exp_drv));
    check({s_rv[now_s] ? s_tag[now_s] : tag, " R12 data"}, 64'(dout), 64'(exp_dat));
    s_rv[now_s] = 1'b0;
    cyc++;
  endtask

  task automatic flush(input int n);
    en_b = 1'b0;
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 0, ALL, "R8");
    en_b = 1'b1;
  endtask

  task automatic run_config(input logic p, input logic l);
    string rt, ot;
    flush(4);
    pipe_mode = p; lin_order = l;
    rt = p ? "R3" : "R2";
    ot = l ? "R5" : "R6";
    // R1: fill every word with back-to-back writes
    for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b1, a, ALL, "R1");
    for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b0, a, ALL, rt);
    // R5/R6: bursts from every offset of several blocks
    for (int s = 0; s < 16; s++) begin
      step(1'b1, 1'b1, s, ALL, ot);
      for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 0, ALL, ot);
      step(1'b1, 1'b0, s, ALL, ot);
      for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 0, ALL, ot);
    end
    // R4: alternating reads and writes with no gap
    for (int i = 0; i < 32; i++) step(1'b1, 1'(i % 2), (i * 5) % DEPTH, ALL, "R4");
    // R11: read directly after write to the same word
    for (int a = 0; a < 8; a++) begin
      step(1'b1, 1'b1, 48 + a, ALL, "R11");
      step(1'b1, 1'b0, 48 + a, ALL, "R11");
    end
    // R7: every byte mask
    for (int m = 0; m < 16; m++) begin
      step(1'b1, 1'b1, 20, 4'(m), "R7");
      step(1'b1, 1'b0, 20, ALL, "R7");
    end
    // R8: every chip-select combination
    for (int c = 0; c < 8; c++) begin
      en_a_n = c[0]; en_b = c[1]; en_c_n = c[2];
      step(1'b1, 1'b0, 30, ALL, "R8");
      step(1'b1, 1'b1, 31, ALL, "R8");
    end
    en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
    step(1'b1, 1'b0, 8, ALL, "R8");
    step(1'b0, 1'b0, 0, ALL, "R8");
    en_b = 1'b0; step(1'b1, 1'b0, 0, ALL, "R8"); en_b = 1'b1;
    step(1'b0, 1'b0, 0, ALL, "R8");
    step(1'b0, 1'b0, 0, ALL, "R8");
    step(1'b1, 1'b0, 31, ALL, "R8");
    step(1'b1, 1'b0, 30, ALL, "R8");
    // R9: output enable toggled while reads stream out
    for (int i = 0; i < 8; i++) begin
      oe_n = 1'(i % 2);
      step(1'b1, 1'b0, i, ALL, "R9");
    end
    oe_n = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, i, ALL, "R9");
    // R10: sleep interrupts a burst and blocks commands
    step(1'b1, 1'b1, 40, ALL, "R10");
    step(1'b1, 1'b0, 12, ALL, "R10");
    step(1'b0, 1'b0, 0, ALL, "R10");
    sleep = 1'b1;
    step(1'b1, 1'b0, 13, ALL, "R10");
    step(1'b0, 1'b0, 0, ALL, "R10");
    step(1'b1, 1'b1, 40, ALL, "R10");
    sleep = 1'b0;
    step(1'b0, 1'b0, 0, ALL, "R10");
    step(1'b1, 1'b0, 40, ALL, "R10");
    step(1'b1, 1'b0, 13, ALL, "R10");
    flush(4);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin s_wv[i] = 1'b0; s_rv[i] = 1'b0; s_wd[i] = '0; s_rd[i] = '0; end
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    m_act = 1'b0; m_wr = 1'b0; m_base = 0; m_cnt = 0;
    rst_n = 1'b0; pipe_mode = 1'b0; lin_order = 1'b1;
    en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
    sleep = 1'b0; oe_n = 1'b0; ld = 1'b0; wr = 1'b0;
    addr = '0; byte_en = '0; din = '0;
    repeat (3) @(negedge clk);
    check("R13 reset drive", 64'(dout_drv), 64'd0);
    check("R13 reset data", 64'(dout), 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, ALL, "R13");
    run_config(1'b0, 1'b1);
    run_config(1'b1, 1'b1);
    run_config(1'b0, 1'b0);
    run_config(1'b1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule